// File: doc/BRIEF.md
# LAPD Address Recognition Filter

This block sits on the receive path behind the flag, bit-unstuffing and CRC stages of a LAPD link. It watches the two address octets at the head of every frame, compares them against four programmable address patterns and forwards only the frames that match. Forwarded frames keep their address octets. A frame that no pattern matches is consumed and discarded up to its end-of-frame strobe, and nothing appears at the output.

Each pattern holds a 6-bit service identifier (SAPI), an expected command/response value with its own compare enable, and a 7-bit terminal identifier (TEI). Each pattern also has two 2-bit widening fields. The TEI field turns the pattern off, or widens it to the broadcast TEI or to every TEI. The SAPI field widens it to SAPI 0, SAPI 63 or every SAPI.

The opening bytes of a frame are held in a five-entry buffer until the frame has proven longer than the minimum length. The block then drains the held bytes and switches to direct pass-through. The match index stays on `out_idx`, and `fwd_en` stays high, for the whole of each forwarded frame.

Both streams use valid/ready handshakes. A byte moves on a cycle where valid and ready are both high. A source must hold valid, data and its strobes unchanged until the byte is taken. While held bytes are draining, `in_ready` is low. During pass-through `in_ready` follows `out_ready`. While the block is collecting or discarding, `in_ready` is high and back-pressure from the output has no effect.

Top module: `lapd_addr_filter`

## Requirements
- R1: A pattern whose TEI mode is 00 never matches, whatever its SAPI mode. When every TEI mode is 00, no frame is forwarded.
- R2: The TEI is bits 7:1 of the second octet. TEI mode 01 matches only the programmed TEI. Mode 10 also matches TEI 127. Mode 11 matches any TEI.
- R3: The SAPI is bits 7:2 of the first octet. SAPI mode 00 matches only the programmed SAPI. Modes 01 and 10 also accept SAPI 0 and SAPI 63 respectively. Mode 11 accepts any SAPI.
- R4: On the programmed-SAPI path, bit 1 of the first octet (command/response) must equal the pattern's `cfg_cr` bit when that pattern's `cfg_cr_chk` bit is 1. The bit is ignored when `cfg_cr_chk` is 0.
- R5: The command/response bit is never compared when a match comes through the SAPI 0, SAPI 63 or any-SAPI path.
- R6: The minimum length is 2 bytes when `cfg_drop_crc` is 0 and 4 bytes when it is 1. A frame no longer than the minimum is never forwarded. A longer frame that matches a pattern is forwarded.
- R7: A forwarded frame leaves byte for byte, address octets included. `out_sof` is high on its first byte only, and `out_eof` is high on its last byte only.
- R8: When several patterns match, `out_idx` reports the lowest-numbered one. It stays constant while `fwd_en` is high.
- R9: A frame that is rejected produces no output. `in_ready` stays high until its end-of-frame byte has been taken.
- R10: While `out_valid` is high and `out_ready` is low, the output holds its byte. While held bytes are draining, `in_ready` is low.
- R11: A pattern with both of its mode fields set to 11 accepts every frame longer than the minimum, whatever the address.
- R12: After reset, `out_valid` and `fwd_en` are low and `in_ready` is high.
- Configuration is bit-packed per pattern k: `cfg_sapi[6k+5:6k]`, `cfg_tei[7k+6:7k]`, `cfg_sapi_mode[2k+1:2k]`, `cfg_tei_mode[2k+1:2k]`, `cfg_cr[k]` and `cfg_cr_chk[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sapi | input | 6*NUM_PAIRS | Programmed SAPI per pattern |
| cfg_cr | input | NUM_PAIRS | Expected command/response bit per pattern |
| cfg_cr_chk | input | NUM_PAIRS | Compare enable for the command/response bit |
| cfg_tei | input | 7*NUM_PAIRS | Programmed TEI per pattern |
| cfg_sapi_mode | input | 2*NUM_PAIRS | SAPI widening mode per pattern |
| cfg_tei_mode | input | 2*NUM_PAIRS | TEI mode per pattern (00 = off) |
| cfg_drop_crc | input | 1 | Raises the minimum frame length from 2 to 4 bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Last byte of a forwarded frame |
| out_idx | output | IDX_W | Lowest matching pattern number |
| fwd_en | output | 1 | High while an accepted frame is being forwarded |

## Verification
The assertions assume that a source never changes a pending input byte before it is taken. They also assume that frames are well formed, with `in_sof` on the first byte and `in_eof` on the last, and that configuration changes only between frames. The bench drives bytes at the falling clock edge and holds each one until it samples `in_ready` high before the rising edge. It changes configuration only after a frame has drained completely. It applies output back-pressure in a fixed repeating pattern, or holds `out_ready` low for a whole rejected frame, and never touches the input during a stall.

// File: rtl/lapd_filt_pkg.sv
package lapd_filt_pkg;
  localparam int SAPI_W   = 6;
  localparam int TEI_W    = 7;
  localparam int ADDR_LEN = 2;
  localparam int CRC_LEN  = 2;

  localparam logic [TEI_W-1:0]  TEI_BCAST   = 7'd127;
  localparam logic [SAPI_W-1:0] SAPI_ALT_LO = 6'd0;
  localparam logic [SAPI_W-1:0] SAPI_ALT_HI = 6'd63;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_EXACT = 2'b01,
    TM_BCAST = 2'b10,
    TM_ANY   = 2'b11
  } tei_mode_e;

  typedef enum logic [1:0] {
    SM_EXACT = 2'b00,
    SM_LOW   = 2'b01,
    SM_HIGH  = 2'b10,
    SM_ANY   = 2'b11
  } sapi_mode_e;

  typedef struct packed {
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } hold_ent_t;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PASS    = 2'd2,
    ST_DROP    = 2'd3
  } flt_state_e;
endpackage

// File: rtl/lapd_pair_match.sv
module lapd_pair_match
  import lapd_filt_pkg::*;
(
  input  logic [SAPI_W-1:0] rx_sapi,
  input  logic              rx_cr,
  input  logic [TEI_W-1:0]  rx_tei,
  input  logic [SAPI_W-1:0] pat_sapi,
  input  logic              pat_cr,
  input  logic              pat_cr_chk,
  input  logic [TEI_W-1:0]  pat_tei,
  input  logic [1:0]        pat_smode,
  input  logic [1:0]        pat_tmode,
  output logic              hit
);
  tei_mode_e  tmode;
  sapi_mode_e smode;
  logic       tei_ok;
  logic       exact_ok;
  logic       widen_ok;

  assign tmode = tei_mode_e'(pat_tmode);
  assign smode = sapi_mode_e'(pat_smode);

  always_comb begin
    unique case (tmode)
      TM_OFF:   tei_ok = 1'b0;
      TM_EXACT: tei_ok = (rx_tei == pat_tei);
      TM_BCAST: tei_ok = (rx_tei == pat_tei) || (rx_tei == TEI_BCAST);
      default:  tei_ok = 1'b1;
    endcase
  end

  // the programmed-SAPI path is the only one that looks at C/R
  assign exact_ok = (rx_sapi == pat_sapi) && (!pat_cr_chk || (rx_cr == pat_cr));

  always_comb begin
    unique case (smode)
      SM_LOW:  widen_ok = (rx_sapi == SAPI_ALT_LO);
      SM_HIGH: widen_ok = (rx_sapi == SAPI_ALT_HI);
      SM_ANY:  widen_ok = 1'b1;
      default: widen_ok = 1'b0;
    endcase
  end

  assign hit = tei_ok && (exact_ok || widen_ok);
endmodule

// File: rtl/lapd_prio_pick.sv
module lapd_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lapd_hold_buf.sv
module lapd_hold_buf
  import lapd_filt_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  hold_ent_t        push_ent,
  input  logic             pop,
  output hold_ent_t        head,
  output logic [7:0]       oct0,
  output logic [7:0]       oct1,
  output logic [CNT_W-1:0] count,
  output logic             at_last
);
  hold_ent_t        mem [DEPTH];
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] rptr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wcnt <= '0;
      rptr <= '0;
    end else begin
      if (push) begin
        mem[wcnt[PTR_W-1:0]] <= push_ent;
        wcnt                 <= wcnt + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  assign head    = mem[rptr[PTR_W-1:0]];
  assign oct0    = mem[0].data;
  assign oct1    = mem[1].data;
  assign count   = wcnt;
  assign at_last = (rptr + 1'b1 == wcnt);

  // R6: the buffer never holds more than the longest minimum plus one byte
  p_hold_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (wcnt < CNT_W'(DEPTH)));

  // R10: a drain step only reads an entry that was written
  p_hold_pop_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (rptr < wcnt));
endmodule

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter
  import lapd_filt_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SAPI_W*NUM_PAIRS-1:0] cfg_sapi,
  input  logic [NUM_PAIRS-1:0]        cfg_cr,
  input  logic [NUM_PAIRS-1:0]        cfg_cr_chk,
  input  logic [TEI_W*NUM_PAIRS-1:0]  cfg_tei,
  input  logic [2*NUM_PAIRS-1:0]      cfg_sapi_mode,
  input  logic [2*NUM_PAIRS-1:0]      cfg_tei_mode,
  input  logic                        cfg_drop_crc,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [7:0]                  in_data,
  input  logic                        in_sof,
  input  logic                        in_eof,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [7:0]                  out_data,
  output logic                        out_sof,
  output logic                        out_eof,
  output logic [IDX_W-1:0]            out_idx,
  output logic                        fwd_en
);
  localparam int HOLD_DEPTH = ADDR_LEN + CRC_LEN + 1;
  localparam int CNT_W      = $clog2(HOLD_DEPTH + 1);

  flt_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;

  logic             hb_clr, hb_push, hb_pop, hb_last;
  hold_ent_t        hb_head, hb_in;
  logic [7:0]       hb_oct0, hb_oct1;
  logic [CNT_W-1:0] hb_cnt;
  logic [CNT_W-1:0] min_len;

  logic [NUM_PAIRS-1:0] hit_vec;
  logic                 pick_any;
  logic [IDX_W-1:0]     pick_idx;

  logic in_fire, out_fire, decide;

  // ---------------- held bytes ----------------
  assign hb_in = '{sof: in_sof, eof: in_eof, data: in_data};

  lapd_hold_buf #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (hb_clr),
    .push     (hb_push),
    .push_ent (hb_in),
    .pop      (hb_pop),
    .head     (hb_head),
    .oct0     (hb_oct0),
    .oct1     (hb_oct1),
    .count    (hb_cnt),
    .at_last  (hb_last)
  );

  // ---------------- address comparison ----------------
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    lapd_pair_match u_match (
      .rx_sapi    (hb_oct0[7:2]),
      .rx_cr      (hb_oct0[1]),
      .rx_tei     (hb_oct1[7:1]),
      .pat_sapi   (cfg_sapi[SAPI_W*k +: SAPI_W]),
      .pat_cr     (cfg_cr[k]),
      .pat_cr_chk (cfg_cr_chk[k]),
      .pat_tei    (cfg_tei[TEI_W*k +: TEI_W]),
      .pat_smode  (cfg_sapi_mode[2*k +: 2]),
      .pat_tmode  (cfg_tei_mode[2*k +: 2]),
      .hit        (hit_vec[k])
    );
  end

  lapd_prio_pick #(.N(NUM_PAIRS)) u_pick (
    .req (hit_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  // ---------------- stream control ----------------
  assign min_len  = cfg_drop_crc ? CNT_W'(ADDR_LEN + CRC_LEN) : CNT_W'(ADDR_LEN);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  // the byte that makes the frame longer than the minimum settles the verdict
  assign decide   = (state_q == ST_COLLECT) && in_fire && (hb_cnt == min_len);

  always_comb begin
    unique case (state_q)
      ST_DRAIN: in_ready = 1'b0;
      ST_PASS:  in_ready = out_ready;
      default:  in_ready = 1'b1;
    endcase
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = in_data;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    if (state_q == ST_DRAIN) begin
      out_valid = 1'b1;
      out_data  = hb_head.data;
      out_sof   = hb_head.sof;
      out_eof   = hb_head.eof;
    end else if (state_q == ST_PASS) begin
      out_valid = in_valid;
      out_sof   = in_sof;
      out_eof   = in_eof;
    end
  end

  always_comb begin
    state_d = state_q;
    hb_clr  = 1'b0;
    hb_push = 1'b0;
    hb_pop  = 1'b0;
    unique case (state_q)
      ST_COLLECT: begin
        if (decide) begin
          if (pick_any) begin
            hb_push = 1'b1;
            state_d = ST_DRAIN;
          end else begin
            hb_clr  = 1'b1;
            state_d = in_eof ? ST_COLLECT : ST_DROP;
          end
        end else if (in_fire) begin
          if (in_eof) hb_clr  = 1'b1;   // too short: silently gone
          else        hb_push = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (out_fire) begin
          hb_pop = 1'b1;
          if (hb_last) begin
            hb_clr  = 1'b1;
            state_d = hb_head.eof ? ST_COLLECT : ST_PASS;
          end
        end
      end
      ST_PASS: begin
        if (in_fire && in_eof) state_d = ST_COLLECT;
      end
      default: begin
        if (in_fire && in_eof) state_d = ST_COLLECT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (decide && pick_any) idx_q <= pick_idx;
    end
  end

  assign out_idx = idx_q;
  assign fwd_en  = (state_q == ST_DRAIN) || (state_q == ST_PASS);

  // ---------------- assertions ----------------
  // R10: input is stalled while held bytes drain
  p_drain_blocks_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> !in_ready);

  // R10: a stalled output byte stays put
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: a rejected frame is swallowed without output or stall
  p_drop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> (!out_valid && in_ready));

  // R6: a frame ending before the minimum is never forwarded
  p_short_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COLLECT) && in_fire && in_eof && (hb_cnt < min_len)) |=> !fwd_en);

  // R8: the reported pattern is the lowest one that hit
  p_pick_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && pick_any) |-> (hit_vec[pick_idx] &&
      ((hit_vec & ((NUM_PAIRS'(1) << pick_idx) - NUM_PAIRS'(1))) == '0)));

  // R8: the index does not move during a forwarded frame
  p_idx_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && $past(fwd_en)) |-> $stable(out_idx));

  // R12: nothing is forwarded straight out of reset
  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |=> (!fwd_en && !out_valid));
endmodule

// File: tb/lapd_addr_filter_tb.sv
module lapd_addr_filter_tb;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [6*NP-1:0] cfg_sapi = '0;
  logic [NP-1:0]   cfg_cr = '0;
  logic [NP-1:0]   cfg_cr_chk = '0;
  logic [7*NP-1:0] cfg_tei = '0;
  logic [2*NP-1:0] cfg_sapi_mode = '0;
  logic [2*NP-1:0] cfg_tei_mode = '0;
  logic            cfg_drop_crc = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eof, fwd_en;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [1:0] out_idx;

  lapd_addr_filter #(.NUM_PAIRS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_sapi(cfg_sapi), .cfg_cr(cfg_cr), .cfg_cr_chk(cfg_cr_chk), .cfg_tei(cfg_tei),
    .cfg_sapi_mode(cfg_sapi_mode), .cfg_tei_mode(cfg_tei_mode), .cfg_drop_crc(cfg_drop_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_idx(out_idx), .fwd_en(fwd_en)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // ---- output back-pressure driver ----
  bit stall_en = 1'b0, ready_low = 1'b0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (ready_low)     out_ready <= 1'b0;
    else if (stall_en) out_ready <= ((cyc % 3) != 2) && ((cyc % 7) != 0);
    else               out_ready <= 1'b1;
  end

  // ---- monitor: samples 1 ns before each rising edge ----
  logic [7:0] cap_data [0:31];
  bit         cap_sof [0:31];
  bit         cap_eof [0:31];
  int  cap_n = 0, side_err = 0, stab_err = 0;
  logic [1:0] cap_idx;
  bit   prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      if (prev_stall && (!out_valid || out_data != prev_data)) stab_err++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (cap_n == 0) cap_idx = out_idx;
        if (!fwd_en || out_idx != cap_idx) side_err++;
        if (cap_n < 32) begin
          cap_data[cap_n] = out_data;
          cap_sof[cap_n]  = out_sof;
          cap_eof[cap_n]  = out_eof;
        end
        cap_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic set_pair(input int k, input int sapi, input bit crv, input bit crchk,
                          input int tei, input int smode, input int tmode);
    cfg_sapi[6*k +: 6]      = 6'(sapi);
    cfg_cr[k]               = crv;
    cfg_cr_chk[k]           = crchk;
    cfg_tei[7*k +: 7]       = 7'(tei);
    cfg_sapi_mode[2*k +: 2] = 2'(smode);
    cfg_tei_mode[2*k +: 2]  = 2'(tmode);
  endtask

  task automatic all_off();
    for (int k = 0; k < NP; k++) set_pair(k, 0, 0, 0, 0, 0, 0);
    cfg_drop_crc = 1'b0;
  endtask

  // reference decision, written from the requirements
  function automatic int ref_pick(input int sapi, input bit cr, input int tei);
    for (int k = 0; k < NP; k++) begin
      int  tm = int'(cfg_tei_mode[2*k +: 2]);
      int  sm = int'(cfg_sapi_mode[2*k +: 2]);
      int  ps = int'(cfg_sapi[6*k +: 6]);
      int  pt = int'(cfg_tei[7*k +: 7]);
      bit  t_ok, s_ok;
      t_ok = (tm == 1 && tei == pt) || (tm == 2 && (tei == pt || tei == 127)) || (tm == 3);
      s_ok = (sapi == ps && (!cfg_cr_chk[k] || cr == cfg_cr[k])) ||
             (sm == 1 && sapi == 0) || (sm == 2 && sapi == 63) || (sm == 3);
      if (t_ok && s_ok) return k;
    end
    return -1;
  endfunction

  logic [7:0] fr [0:15];
  int drv_wait = 0;

  task automatic drive_frame(input int len);
    drv_wait = 0;
    for (int i = 0; i < len; i++) begin
      bit taken;
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == len - 1);
      taken = 1'b0;
      while (!taken) begin
        #4;
        taken = in_ready;
        if (!taken) begin drv_wait++; @(negedge clk); end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input int sapi, input bit cr, input int tei, input int len, input string tag);
    int exp, minl;
    fr[0] = {6'(sapi), cr, 1'b0};
    fr[1] = {7'(tei), 1'b1};
    for (int i = 2; i < 16; i++) fr[i] = 8'(8'h30 + i * 7 + sapi);
    minl = cfg_drop_crc ? 4 : 2;
    exp = (len > minl) ? ref_pick(sapi, cr, tei) : -1;
    cap_n = 0; side_err = 0;
    drive_frame(len);
    repeat (8) @(negedge clk);
    if (exp < 0) begin
      check(cap_n == 0, tag, "bytes forwarded for rejected frame", cap_n, 0);
    end else begin
      bit ok = (cap_n == len) && (side_err == 0);
      for (int i = 0; i < len && i < 32; i++)
        if (cap_data[i] != fr[i] || cap_sof[i] != (i == 0) || cap_eof[i] != (i == len - 1)) ok = 1'b0;
      check(ok, tag, "R7 forwarded bytes/strobes (count)", cap_n, len);
      check(int'(cap_idx) == exp, tag, "R8 match index", int'(cap_idx), exp);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk); #4;
    check(!out_valid && !fwd_en && in_ready, "R12", "reset outputs {ov,fe,ir}",
          {out_valid, fwd_en, in_ready}, 1);
  endtask

  task automatic t_tei_off();
    all_off();
    set_pair(0, 5, 0, 0, 9, 3, 0);
    for (int k = 1; k < NP; k++) set_pair(k, 5, 0, 0, 9, 3, 0);
    run_frame(5, 0, 9, 6, "R1");
    run_frame(22, 1, 80, 6, "R1");
  endtask

  task automatic t_tei_modes();
    all_off();
    set_pair(1, 16, 0, 0, 40, 0, 1);
    run_frame(16, 0, 40, 5, "R2");
    run_frame(16, 0, 127, 5, "R2");
    set_pair(1, 16, 0, 0, 40, 0, 2);
    run_frame(16, 0, 127, 5, "R2");
    run_frame(16, 0, 41, 5, "R2");
    set_pair(1, 16, 0, 0, 40, 0, 3);
    run_frame(16, 1, 41, 5, "R2");
  endtask

  task automatic t_sapi_modes();
    all_off();
    set_pair(2, 12, 0, 0, 64, 0, 1);
    run_frame(12, 0, 64, 4, "R3");
    run_frame(0, 0, 64, 4, "R3");
    set_pair(2, 12, 0, 0, 64, 1, 1);
    run_frame(0, 0, 64, 4, "R3");
    run_frame(63, 0, 64, 4, "R3");
    set_pair(2, 12, 0, 0, 64, 2, 1);
    run_frame(63, 0, 64, 4, "R3");
    set_pair(2, 12, 0, 0, 64, 3, 1);
    run_frame(33, 0, 64, 4, "R3");
  endtask

  task automatic t_cr();
    all_off();
    set_pair(0, 20, 1, 1, 5, 0, 1);
    run_frame(20, 1, 5, 4, "R4");
    run_frame(20, 0, 5, 4, "R4");
    set_pair(0, 20, 1, 0, 5, 0, 1);
    run_frame(20, 0, 5, 4, "R4");
  endtask

  task automatic t_cr_widen();
    all_off();
    set_pair(3, 7, 1, 1, 3, 1, 1);
    run_frame(0, 0, 3, 4, "R5");
    set_pair(3, 7, 1, 1, 3, 2, 1);
    run_frame(63, 0, 3, 4, "R5");
    set_pair(3, 7, 1, 1, 3, 3, 1);
    run_frame(50, 0, 3, 4, "R5");
  endtask

  task automatic t_minlen();
    all_off();
    set_pair(0, 9, 0, 0, 11, 0, 1);
    run_frame(9, 0, 11, 1, "R6");
    run_frame(9, 0, 11, 2, "R6");
    run_frame(9, 0, 11, 3, "R6");
    cfg_drop_crc = 1'b1;
    run_frame(9, 0, 11, 4, "R6");
    run_frame(9, 0, 11, 5, "R6");
    cfg_drop_crc = 1'b0;
  endtask

  task automatic t_prio();
    all_off();
    set_pair(1, 30, 0, 0, 70, 0, 1);
    set_pair(3, 30, 0, 0, 70, 0, 1);
    run_frame(30, 0, 70, 6, "R8");
    set_pair(1, 30, 0, 0, 70, 0, 0);
    run_frame(30, 0, 70, 6, "R8");
  endtask

  task automatic t_promisc();
    all_off();
    set_pair(2, 1, 0, 1, 1, 3, 3);
    run_frame(45, 1, 100, 7, "R11");
    cfg_drop_crc = 1'b1;
    run_frame(17, 0, 2, 4, "R11");
    run_frame(17, 0, 2, 5, "R11");
    cfg_drop_crc = 1'b0;
    set_pair(0, 45, 1, 1, 100, 0, 1);
    run_frame(45, 1, 100, 7, "R11");
  endtask

  task automatic t_drop();
    all_off();
    set_pair(0, 2, 0, 0, 2, 0, 1);
    ready_low = 1'b1;
    run_frame(3, 0, 2, 10, "R9");
    check(drv_wait == 0, "R9", "input stall cycles on rejected frame", drv_wait, 0);
    ready_low = 1'b0;
  endtask

  task automatic t_backpressure();
    all_off();
    set_pair(1, 40, 0, 0, 90, 0, 1);
    stab_err = 0;
    stall_en = 1'b1;
    run_frame(40, 0, 90, 14, "R10");
    cfg_drop_crc = 1'b1;
    run_frame(40, 0, 90, 6, "R10");
    cfg_drop_crc = 1'b0;
    stall_en = 1'b0;
    check(stab_err == 0, "R10", "output changed while stalled (count)", stab_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tei_off();
    t_tei_modes();
    t_sapi_modes();
    t_cr();
    t_cr_widen();
    t_minlen();
    t_prio();
    t_promisc();
    t_drop();
    t_backpressure();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule